// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block maintains the modem status byte of a 16550-style serial port. Every clock it samples four modem status lines (clear-to-send, data-set-ready, ring indicator, carrier detect) and holds the result in the upper nibble of the status byte. When the port is in loopback mode, four of the modem control outputs take the place of the external lines. The lower nibble holds sticky change flags that record line activity since the host last read the byte.

The host reads the status byte combinationally from `msr_o` and pulses `msr_rd_i` during that access. The pulse clears all four change flags at the next clock edge. The `delta_any_o` output tells the interrupt logic that at least one change flag is set. Input synchronization and the modem control register itself live outside this block. The block receives the control register's value on `mcr_i` and uses its loopback bit.

Top module: `msr_delta_tracker`

## Requirements
- R1: When `mcr_i[4]` (loopback) is 1, the status nibble follows the control outputs one cycle later: `msr_o[4]` = `mcr_i[1]`, `msr_o[5]` = `mcr_i[0]`, `msr_o[6]` = `mcr_i[2]` and `msr_o[7]` = `mcr_i[3]`.
- R2: When `mcr_i[4]` is 0, `msr_o[7:4]` equals `lines_i[3:0]` one cycle later. The line order is bit0 clear-to-send, bit1 data-set-ready, bit2 ring, bit3 carrier.
- R3: A change in either direction of clear-to-send, data-set-ready or carrier between consecutive samples sets `msr_o[0]`, `msr_o[1]` or `msr_o[3]` respectively, in the same cycle that the new status appears.
- R4: The ring change flag `msr_o[2]` is set only when the ring status goes from 1 to 0. A rising ring leaves it unchanged.
- R5: A change flag that is set stays set while no read occurs, whatever the lines do.
- R6: A cycle with `msr_rd_i` high clears all four change flags at the following edge.
- R7: If a read and a new change fall in the same cycle, the flag for that change is set after the edge.
- R8: `delta_any_o` is 1 exactly when any of `msr_o[3:0]` is 1.
- R9: After synchronous reset, `msr_o` is 0 and `delta_any_o` is 0. A line sampled high in the first cycle after reset counts as a change from 0.
- R10: In loopback the external lines have no effect on `msr_o`. Outside loopback, `mcr_i[3:0]` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_i | input | 5 | Modem control value: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback |
| lines_i | input | 4 | Synchronized active-high modem lines: bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD |
| msr_rd_i | input | 1 | Host read strobe for the status byte |
| msr_o | output | 8 | Status byte: [7:4] line status, [3:0] change flags |
| delta_any_o | output | 1 | OR of the change flags |

## Verification
The bench makes the ring line rise and then fall. A tracker that treats ring like the other lines would flag the rise. The bench toggles a line back to its old value before any read, so a design that recomputes the flags from the current difference would lose the flag. It also puts a read and a fresh change in the same cycle, where a design that gives the clear priority would drop the new event. In loopback it moves the external lines, and outside loopback it moves the control bits. A wrong mapping, or a selector that leaks one source into the other, shows up in the status nibble.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int LINE_W  = 4;
    localparam int MSR_W   = 2 * LINE_W;
    localparam int MCR_W   = 5;

    // control register bit positions (decoded by the neighbouring register)
    localparam int MCR_DTR  = 0;
    localparam int MCR_RTS  = 1;
    localparam int MCR_OUT1 = 2;
    localparam int MCR_OUT2 = 3;
    localparam int MCR_LOOP = 4;

    // lines whose flag fires only on a falling edge (ring indicator)
    localparam logic [LINE_W-1:0] FALL_ONLY = 4'b0100;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_set_t;

    typedef enum logic {
        SRC_EXTERNAL = 1'b0,
        SRC_LOOPBACK = 1'b1
    } line_src_e;

    function automatic line_set_t loop_map(input logic [MCR_W-1:0] mcr);
        line_set_t s;
        s.cts = mcr[MCR_RTS];
        s.dsr = mcr[MCR_DTR];
        s.ri  = mcr[MCR_OUT1];
        s.dcd = mcr[MCR_OUT2];
        return s;
    endfunction

endpackage

// File: rtl/msr_src_sel.sv
module msr_src_sel
    import msr_pkg::*;
(
    input  logic [MCR_W-1:0]  mcr_i,
    input  logic [LINE_W-1:0] ext_i,
    output line_set_t         sel_o
);
    line_src_e src;

    always_comb begin
        src = line_src_e'(mcr_i[MCR_LOOP]);
        case (src)
            SRC_LOOPBACK: sel_o = loop_map(mcr_i);
            default:      sel_o = line_set_t'(ext_i);
        endcase
    end
endmodule

// File: rtl/msr_change_det.sv
module msr_change_det #(
    parameter int                 N         = 4,
    parameter logic [N-1:0]       FALL_MASK = '0
) (
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] next_i,
    output logic [N-1:0] change_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        if (FALL_MASK[i]) begin : g_fall
            assign change_o[i] = prev_i[i] & ~next_i[i];
        end else begin : g_any
            assign change_o[i] = prev_i[i] ^ next_i[i];
        end
    end
endmodule

// File: rtl/msr_delta_reg.sv
module msr_delta_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stat_d,
    input  logic [N-1:0] change_i,
    input  logic         clr_i,
    output logic [N-1:0] stat_q,
    output logic [N-1:0] delta_q
);
    logic [N-1:0] keep;

    always_comb keep = clr_i ? '0 : delta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            delta_q <= '0;
        end else begin
            stat_q  <= stat_d;
            delta_q <= keep | change_i;
        end
    end
endmodule

// File: rtl/msr_delta_tracker.sv
module msr_delta_tracker
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MCR_W-1:0]  mcr_i,
    input  logic [LINE_W-1:0] lines_i,
    input  logic              msr_rd_i,
    output logic [MSR_W-1:0]  msr_o,
    output logic              delta_any_o
);
    line_set_t          cur;
    logic [LINE_W-1:0]  stat_q;
    logic [LINE_W-1:0]  delta_q;
    logic [LINE_W-1:0]  change;

    msr_src_sel u_sel (
        .mcr_i (mcr_i),
        .ext_i (lines_i),
        .sel_o (cur)
    );

    msr_change_det #(.N(LINE_W), .FALL_MASK(FALL_ONLY)) u_det (
        .prev_i   (stat_q),
        .next_i   (cur),
        .change_o (change)
    );

    msr_delta_reg #(.N(LINE_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .stat_d   (cur),
        .change_i (change),
        .clr_i    (msr_rd_i),
        .stat_q   (stat_q),
        .delta_q  (delta_q)
    );

    assign msr_o       = {stat_q, delta_q};
    assign delta_any_o = |delta_q;
endmodule

// File: rtl/msr_delta_tracker_chk.sv
module msr_delta_tracker_chk
    import msr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MCR_W-1:0]  mcr_i,
    input logic [LINE_W-1:0] lines_i,
    input logic              msr_rd_i,
    input logic [MSR_W-1:0]  msr_o
);
    p_loop_map_r1: assert property (@(posedge clk) disable iff (rst)
        mcr_i[MCR_LOOP] |=> msr_o[7:4] == {$past(mcr_i[MCR_OUT2]), $past(mcr_i[MCR_OUT1]),
                                           $past(mcr_i[MCR_DTR]),  $past(mcr_i[MCR_RTS])});

    p_ext_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !mcr_i[MCR_LOOP] |=> msr_o[7:4] == $past(lines_i));

    p_ring_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(msr_o[2]) |-> ($past(msr_o[6]) && !msr_o[6]));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !msr_rd_i |=> (msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0]));

    p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
        msr_rd_i |=> (msr_o[3:0] == 4'b0) || (msr_o[7:4] != $past(msr_o[7:4])));
endmodule

bind msr_delta_tracker msr_delta_tracker_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mcr_i    (mcr_i),
    .lines_i  (lines_i),
    .msr_rd_i (msr_rd_i),
    .msr_o    (msr_o)
);

// File: tb/tb_msr_delta_tracker.sv
module tb_msr_delta_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] mcr_i = '0;
    logic [3:0] lines_i = '0;
    logic       msr_rd_i = 1'b0;
    logic [7:0] msr_o;
    logic       delta_any_o;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] q_msr[$];
    string      q_tag[$];
    logic [3:0] m_stat = '0;
    logic [3:0] m_delta = '0;

    always #5 clk = ~clk;

    msr_delta_tracker dut (
        .clk(clk), .rst(rst), .mcr_i(mcr_i), .lines_i(lines_i),
        .msr_rd_i(msr_rd_i), .msr_o(msr_o), .delta_any_o(delta_any_o)
    );

    // driver: applies one cycle of stimulus and predicts the result
    task automatic step(input logic [4:0] mcr, input logic [3:0] ext,
                        input logic rd, input string tag);
        logic [3:0] nxt;
        logic [3:0] ch;
        @(negedge clk);
        mcr_i = mcr; lines_i = ext; msr_rd_i = rd;
        if (mcr[4]) nxt = {mcr[3], mcr[2], mcr[0], mcr[1]};
        else        nxt = ext;
        ch[0] = nxt[0] ^ m_stat[0];
        ch[1] = nxt[1] ^ m_stat[1];
        ch[3] = nxt[3] ^ m_stat[3];
        ch[2] = m_stat[2] & ~nxt[2];
        m_delta = (rd ? 4'b0 : m_delta) | ch;
        m_stat  = nxt;
        q_msr.push_back({m_stat, m_delta});
        q_tag.push_back(tag);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #2;
        if (q_msr.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_msr.pop_front();
            t = q_tag.pop_front();
            n_run++;
            if (msr_o !== e) begin
                n_fail++;
                $display("FAIL %s: msr actual %b expected %b", t, msr_o, e);
            end
            n_run++;
            if (delta_any_o !== (|e[3:0])) begin
                n_fail++;
                $display("FAIL R8: delta_any actual %b expected %b", delta_any_o, |e[3:0]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        n_run++;
        if (msr_o !== 8'h00 || delta_any_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: reset msr actual %h expected 00", msr_o);
        end
        step(5'h00, 4'b0000, 1'b0, "R9 idle");
        step(5'h00, 4'b0001, 1'b0, "R3 cts rise");
        step(5'h00, 4'b0001, 1'b1, "R6 read clear");
        step(5'h00, 4'b0101, 1'b0, "R4 ring rise no flag");
        step(5'h00, 4'b0001, 1'b0, "R4 ring fall flag");
        step(5'h00, 4'b0011, 1'b0, "R3 dsr rise");
        step(5'h00, 4'b0001, 1'b0, "R5 dsr back sticky");
        step(5'h0F, 4'b1001, 1'b0, "R10 mcr ignored, R3 dcd");
        step(5'h0F, 4'b1001, 1'b1, "R6 read all clear");
        step(5'h00, 4'b0000, 1'b1, "R7 read with change");
        step(5'h00, 4'b0000, 1'b1, "R6 second read");
        step(5'h12, 4'b0000, 1'b0, "R1 rts->cts");
        step(5'h11, 4'b1111, 1'b0, "R1 dtr->dsr R10");
        step(5'h14, 4'b0000, 1'b1, "R1 out1->ri");
        step(5'h18, 4'b0101, 1'b0, "R1 out2->dcd R4");
        step(5'h18, 4'b0000, 1'b1, "R10 ext ignored");
        step(5'h00, 4'b1010, 1'b0, "R2 ext resume");
        step(5'h00, 4'b1010, 1'b1, "R6 final read");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule